// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds eight one-bit semaphore latches that two ports, left and right, share for claiming common resources. They are separate from any memory array. A port selects the bank by driving its semaphore select low while its memory enable stays inactive. It writes a zero to ask for a semaphore and writes a one to give it back or to withdraw a request. It then reads the same location to learn whether it holds the semaphore.

Each latch remembers a pending request from each side as well as the current holder. Because of this, the two ports see different values: zero for the holder and one for everyone else. When the holder gives a semaphore back and the other side is waiting, ownership passes across in the same clock edge.

Top module: `sem_bank`

## Requirements
- R1: The semaphore is picked by address bits [2:0] of the accessing port. All higher address bits have no effect.
- R2: A port accesses the bank only in a cycle where its semaphore select is low and its memory enable is high. In any other cycle its inputs change no semaphore and start no read.
- R3: A write (read/write input low) uses only data bit 0. A value of 0 records a request from that port. A value of 1 releases the semaphore, or cancels that port's request if the port does not hold it.
- R4: A request to a free semaphore grants it at the clock edge that samples the write. From then on a read returns 0 on the granted port and 1 on the other port.
- R5: At most one port holds a semaphore. A write from the non-holder cannot take the semaphore or clear the holder's claim. A zero written by the non-holder only leaves a pending request.
- R6: When the holder writes 1 and the other port has a pending request, the other port holds the semaphore from that same edge on.
- R7: Once neither port holds or requests a semaphore, it reads 1 on both ports.
- R8: Read data drives the port's semaphore value on every data output bit.
- R9: If both ports request the same free semaphore at the same edge, the left port is granted and the right request stays pending.
- R10: Read data is registered at the edge that samples the first cycle of a read access. It reflects the state before any write sampled at that edge, and it stays unchanged while the read access continues.
- R11: Reset frees all eight semaphores, clears all requests and sets both read-data outputs to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| leftSemN | input | 1 | Left semaphore select, active low |
| leftMemN | input | 1 | Left memory enable, active low (must be high for a semaphore access) |
| leftRdWrN | input | 1 | Left direction: 1 read, 0 write |
| leftAddr | input | ADDR_W | Left address; bits [2:0] pick the semaphore |
| leftDin | input | DATA_W | Left write data; bit 0 used |
| leftDout | output | DATA_W | Left registered read data |
| rightSemN | input | 1 | Right semaphore select, active low |
| rightMemN | input | 1 | Right memory enable, active low (must be high for a semaphore access) |
| rightRdWrN | input | 1 | Right direction: 1 read, 0 write |
| rightAddr | input | ADDR_W | Right address; bits [2:0] pick the semaphore |
| rightDin | input | DATA_W | Right write data; bit 0 used |
| rightDout | output | DATA_W | Right registered read data |

## Verification
A write changes ownership at the rising edge that samples it. A read started in the next cycle shows the change. The read data itself appears right after the edge that samples the first cycle of a read, and it does not move again until a new read starts. The bench therefore drives every input on the falling edge and updates its model from the state before the edge. It compares both read-data outputs on the following falling edge. Long reads, same-cycle write-and-read pairs and handovers during a held read are directed cases. They confirm that read data changes only at the edge a read starts, which R10 requires.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int SEM_COUNT = 8;
  localparam int SEM_IDX_W = $clog2(SEM_COUNT);

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } semOwner_t;

  // strobes from the port decoder to the latch datapath
  typedef struct packed {
    logic [SEM_COUNT-1:0] wrLeft;
    logic [SEM_COUNT-1:0] wrRight;
    logic                 valLeft;
    logic                 valRight;
    logic                 capLeft;
    logic                 capRight;
    logic [SEM_IDX_W-1:0] idxLeft;
    logic [SEM_IDX_W-1:0] idxRight;
  } semStrobe_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 leftSemN,
  input  logic                 leftMemN,
  input  logic                 leftRdWrN,
  input  logic [SEM_IDX_W-1:0] leftIdx,
  input  logic                 leftBit,
  input  logic                 rightSemN,
  input  logic                 rightMemN,
  input  logic                 rightRdWrN,
  input  logic [SEM_IDX_W-1:0] rightIdx,
  input  logic                 rightBit,
  output semStrobe_t           strobe
);
  localparam logic [SEM_COUNT-1:0] ONE_HOT0 = {{(SEM_COUNT-1){1'b0}}, 1'b1};

  logic leftAcc, rightAcc, leftRd, rightRd, leftWr, rightWr;
  logic leftRdPrev, rightRdPrev;

  // a bank access needs select low and the memory enable inactive
  assign leftAcc  = !leftSemN && leftMemN;
  assign rightAcc = !rightSemN && rightMemN;
  assign leftRd   = leftAcc && leftRdWrN;
  assign rightRd  = rightAcc && rightRdWrN;
  assign leftWr   = leftAcc && !leftRdWrN;
  assign rightWr  = rightAcc && !rightRdWrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftRdPrev  <= 1'b0;
      rightRdPrev <= 1'b0;
    end else begin
      leftRdPrev  <= leftRd;
      rightRdPrev <= rightRd;
    end
  end

  always_comb begin
    strobe.wrLeft   = leftWr  ? (ONE_HOT0 << leftIdx)  : '0;
    strobe.wrRight  = rightWr ? (ONE_HOT0 << rightIdx) : '0;
    strobe.valLeft  = leftBit;
    strobe.valRight = rightBit;
    strobe.capLeft  = leftRd && !leftRdPrev;
    strobe.capRight = rightRd && !rightRdPrev;
    strobe.idxLeft  = leftIdx;
    strobe.idxRight = rightIdx;
  end
endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobe_t           strobe,
  output logic [SEM_COUNT-1:0] ownLeft,
  output logic [SEM_COUNT-1:0] ownRight,
  output logic [DATA_W-1:0]    leftDout,
  output logic [DATA_W-1:0]    rightDout
);
  for (genvar g = 0; g < SEM_COUNT; g++) begin : g_latch
    logic      reqLeft, reqRight, nReqLeft, nReqRight;
    semOwner_t owner, nOwner;

    // a write from a port replaces that port's request bit
    assign nReqLeft  = strobe.wrLeft[g]  ? !strobe.valLeft  : reqLeft;
    assign nReqRight = strobe.wrRight[g] ? !strobe.valRight : reqRight;

    always_comb begin
      unique case (owner)
        OWN_LEFT:  nOwner = nReqLeft  ? OWN_LEFT  : (nReqRight ? OWN_RIGHT : OWN_NONE);
        OWN_RIGHT: nOwner = nReqRight ? OWN_RIGHT : (nReqLeft  ? OWN_LEFT  : OWN_NONE);
        default:   nOwner = nReqLeft  ? OWN_LEFT  : (nReqRight ? OWN_RIGHT : OWN_NONE);
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqLeft  <= 1'b0;
        reqRight <= 1'b0;
        owner    <= OWN_NONE;
      end else begin
        reqLeft  <= nReqLeft;
        reqRight <= nReqRight;
        owner    <= nOwner;
      end
    end

    assign ownLeft[g]  = (owner == OWN_LEFT);
    assign ownRight[g] = (owner == OWN_RIGHT);
  end

  // read data is captured once per read, from the state before this edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftDout  <= '1;
      rightDout <= '1;
    end else begin
      if (strobe.capLeft)  leftDout  <= {DATA_W{!ownLeft[strobe.idxLeft]}};
      if (strobe.capRight) rightDout <= {DATA_W{!ownRight[strobe.idxRight]}};
    end
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftSemN,
  input  logic              leftMemN,
  input  logic              leftRdWrN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic [DATA_W-1:0] leftDin,
  output logic [DATA_W-1:0] leftDout,
  input  logic              rightSemN,
  input  logic              rightMemN,
  input  logic              rightRdWrN,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic [DATA_W-1:0] rightDin,
  output logic [DATA_W-1:0] rightDout
);
  semStrobe_t           strobe;
  logic [SEM_COUNT-1:0] ownLeft, ownRight;

  // upper address bits and upper data bits play no part in a bank access
  logic unusedBits;
  assign unusedBits = ^{leftAddr[ADDR_W-1:SEM_IDX_W], rightAddr[ADDR_W-1:SEM_IDX_W],
                        leftDin[DATA_W-1:1], rightDin[DATA_W-1:1]};

  sem_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .leftSemN   (leftSemN),
    .leftMemN   (leftMemN),
    .leftRdWrN  (leftRdWrN),
    .leftIdx    (leftAddr[SEM_IDX_W-1:0]),
    .leftBit    (leftDin[0]),
    .rightSemN  (rightSemN),
    .rightMemN  (rightMemN),
    .rightRdWrN (rightRdWrN),
    .rightIdx   (rightAddr[SEM_IDX_W-1:0]),
    .rightBit   (rightDin[0]),
    .strobe     (strobe)
  );

  sem_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ownLeft   (ownLeft),
    .ownRight  (ownRight),
    .leftDout  (leftDout),
    .rightDout (rightDout)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
  import sem_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 leftSemN,
  input logic                 leftMemN,
  input logic                 leftRdWrN,
  input logic                 rightSemN,
  input logic                 rightMemN,
  input logic                 rightRdWrN,
  input logic [SEM_COUNT-1:0] ownLeft,
  input logic [SEM_COUNT-1:0] ownRight,
  input logic [DATA_W-1:0]    leftDout,
  input logic [DATA_W-1:0]    rightDout
);
  logic leftAcc, rightAcc, leftRd, rightRd;
  logic leftRdPrev, rightRdPrev, anyAccPrev, armed;
  logic [SEM_COUNT-1:0] ownLeftPrev, ownRightPrev;

  assign leftAcc  = !leftSemN && leftMemN;
  assign rightAcc = !rightSemN && rightMemN;
  assign leftRd   = leftAcc && leftRdWrN;
  assign rightRd  = rightAcc && rightRdWrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftRdPrev   <= 1'b0;
      rightRdPrev  <= 1'b0;
      anyAccPrev   <= 1'b0;
      armed        <= 1'b0;
      ownLeftPrev  <= '0;
      ownRightPrev <= '0;
    end else begin
      leftRdPrev   <= leftRd;
      rightRdPrev  <= rightRd;
      anyAccPrev   <= leftAcc || rightAcc;
      armed        <= 1'b1;
      ownLeftPrev  <= ownLeft;
      ownRightPrev <= ownRight;
    end
  end

  // R5: never two holders
  assert_single_holder_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ownLeft & ownRight) == '0);

  // R8: every read data line carries the same value
  assert_uniform_left_R8: assert property (@(posedge clk) disable iff (!rstN)
    leftDout == {DATA_W{leftDout[0]}});
  assert_uniform_right_R8: assert property (@(posedge clk) disable iff (!rstN)
    rightDout == {DATA_W{rightDout[0]}});

  // R10: read data is held while the read continues
  assert_read_hold_left_R10: assert property (@(posedge clk) disable iff (!rstN)
    (leftRdPrev && leftRd) |=> $stable(leftDout));
  assert_read_hold_right_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rightRdPrev && rightRd) |=> $stable(rightDout));

  // R2: with no access in the previous cycle, ownership did not move
  assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !anyAccPrev) |-> (ownLeft == ownLeftPrev && ownRight == ownRightPrev));

  // R11: reset leaves every semaphore free
  assert_reset_free_R11: assert property (@(posedge clk)
    !rstN |=> (ownLeft == '0 && ownRight == '0));
endmodule

bind sem_bank sem_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .leftSemN   (leftSemN),
  .leftMemN   (leftMemN),
  .leftRdWrN  (leftRdWrN),
  .rightSemN  (rightSemN),
  .rightMemN  (rightMemN),
  .rightRdWrN (rightRdWrN),
  .ownLeft    (ownLeft),
  .ownRight   (ownRight),
  .leftDout   (leftDout),
  .rightDout  (rightDout)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 9;
  localparam int NSEM = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSemN = 1'b1, lMemN = 1'b1, lRdWrN = 1'b1;
  logic rSemN = 1'b1, rMemN = 1'b1, rRdWrN = 1'b1;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic [DATA_W-1:0] lDin = '0, rDin = '0;
  logic [DATA_W-1:0] lDout, rDout;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model: 0 free, 1 left, 2 right
  int mOwn [NSEM];
  bit mReqL [NSEM];
  bit mReqR [NSEM];
  bit mPrevRdL = 0, mPrevRdR = 0;
  logic [DATA_W-1:0] expL = '1, expR = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sem_bank (
    .clk(clk), .rstN(rstN),
    .leftSemN(lSemN), .leftMemN(lMemN), .leftRdWrN(lRdWrN),
    .leftAddr(lAddr), .leftDin(lDin), .leftDout(lDout),
    .rightSemN(rSemN), .rightMemN(rMemN), .rightRdWrN(rRdWrN),
    .rightAddr(rAddr), .rightDin(rDin), .rightDout(rDout)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below 50000", cycles);
      summary();
    end
  end

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nextOwner(int own, bit nl, bit nr);
    if (own == 2) return nr ? 2 : (nl ? 1 : 0);
    return nl ? 1 : (nr ? 2 : 0);
  endfunction

  // model update from the pre-edge state, then one clock, then compare
  task automatic step(string tag,
                      bit ls, bit lm, bit lr, logic [ADDR_W-1:0] la, logic [DATA_W-1:0] ld,
                      bit rs, bit rm, bit rr, logic [ADDR_W-1:0] ra, logic [DATA_W-1:0] rd);
    bit accL, accR, rdL, rdR;
    lSemN = ls; lMemN = lm; lRdWrN = lr; lAddr = la; lDin = ld;
    rSemN = rs; rMemN = rm; rRdWrN = rr; rAddr = ra; rDin = rd;
    accL = !ls && lm; accR = !rs && rm;
    rdL = accL && lr; rdR = accR && rr;
    if (rdL && !mPrevRdL) expL = {DATA_W{mOwn[la[2:0]] != 1}};
    if (rdR && !mPrevRdR) expR = {DATA_W{mOwn[ra[2:0]] != 2}};
    mPrevRdL = rdL; mPrevRdR = rdR;
    for (int i = 0; i < NSEM; i++) begin
      bit nl, nr;
      nl = (accL && !lr && la[2:0] == i) ? !ld[0] : mReqL[i];
      nr = (accR && !rr && ra[2:0] == i) ? !rd[0] : mReqR[i];
      mOwn[i] = nextOwner(mOwn[i], nl, nr);
      mReqL[i] = nl; mReqR[i] = nr;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " left"}, lDout, expL);
    check({tag, " right"}, rDout, expR);
  endtask

  // shorthands: one port acts, other idle; both then read a semaphore
  task automatic wrL(string tag, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step(tag, 0, 1, 0, a, d, 1, 1, 1, 0, 0);
  endtask
  task automatic wrR(string tag, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    step(tag, 1, 1, 1, 0, 0, 0, 1, 0, a, d);
  endtask
  task automatic readBoth(string tag, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] eL, logic [DATA_W-1:0] eR);
    step(tag, 1, 1, 1, 0, 0, 1, 1, 1, 0, 0);
    step(tag, 0, 1, 1, a, 0, 0, 1, 1, a, 0);
    check({tag, " direct left"}, lDout, eL);
    check({tag, " direct right"}, rDout, eR);
  endtask

  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] ZERO = '0;

  initial begin
    for (int i = 0; i < NSEM; i++) begin mOwn[i] = 0; mReqL[i] = 0; mReqR[i] = 0; end
    void'($urandom(32'h5EA5_0011));
    repeat (3) @(negedge clk);
    check("R11 reset left", lDout, ONES);
    check("R11 reset right", rDout, ONES);
    rstN = 1'b1;
    @(negedge clk);
    readBoth("R11", 3, ONES, ONES);

    // R4 / R1: grant through an address with upper bits set
    wrL("R4", 17'h1_FFF2, 9'h000);
    readBoth("R4", 2, ZERO, ONES);
    readBoth("R1", 17'h0_A5AA, ZERO, ONES);

    // R5: non-holder cannot clear, its zero only pends
    wrR("R5", 2, 9'h001);
    readBoth("R5", 2, ZERO, ONES);
    wrR("R5", 2, 9'h000);
    readBoth("R5", 2, ZERO, ONES);

    // R6: release hands over to the pending side
    wrL("R6", 2, 9'h001);
    readBoth("R6", 2, ONES, ZERO);

    // R7: last release frees it on both ports
    wrR("R7", 2, 9'h001);
    readBoth("R7", 2, ONES, ONES);

    // R9: same-edge requests, left wins
    step("R9", 0, 1, 0, 5, 0, 0, 1, 0, 5, 0);
    readBoth("R9", 5, ZERO, ONES);
    wrL("R9", 5, 9'h001);
    readBoth("R9", 5, ONES, ZERO);
    wrR("R9", 5, 9'h001);

    // R2: memory enable active or select high blocks the access
    step("R2", 0, 0, 0, 4, 0, 1, 1, 0, 4, 0);
    readBoth("R2", 4, ONES, ONES);

    // R3: only bit 0 of the data counts
    wrR("R3", 1, 9'h1FE);
    readBoth("R3", 1, ONES, ZERO);
    wrR("R3", 1, 9'h001);
    readBoth("R3", 1, ONES, ONES);

    // R10: held read ignores a handover during it
    wrL("R10", 6, 0);
    wrR("R10", 6, 0);
    step("R10", 1, 1, 1, 0, 0, 0, 1, 1, 6, 0);
    check("R10 start", rDout, ONES);
    step("R10", 0, 1, 0, 6, 1, 0, 1, 1, 6, 0);
    step("R10", 1, 1, 1, 0, 0, 0, 1, 1, 6, 0);
    check("R10 held", rDout, ONES);
    readBoth("R10", 6, ONES, ZERO);
    wrR("R10", 6, 1);

    // R10: read start sees state before a same-edge write; R8 all lines
    step("R10", 0, 1, 0, 7, 0, 0, 1, 1, 7, 0);
    check("R8 right lines", rDout, ONES);
    readBoth("R8", 7, ZERO, ONES);
    wrL("R8", 7, 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      step("R3 random",
           ($urandom % 3) == 0, ($urandom % 6) != 0, $urandom % 2,
           ADDR_W'($urandom), DATA_W'($urandom),
           ($urandom % 3) == 0, ($urandom % 6) != 0, $urandom % 2,
           ADDR_W'($urandom), DATA_W'($urandom));
    end
    summary();
  end
endmodule